// File: doc/BRIEF.md
# Group-Two Operate Microinstruction Unit

This block carries out the second class of operate microinstructions of a 12-bit accumulator processor. An instruction strobe presents a 12-bit instruction word together with the current accumulator, the link bit and a 12-bit front-panel switch word. One clock later the unit returns three results. The first is a skip decision that the program-counter logic elsewhere uses to step over the next word. The second is the new accumulator value. The third is a halt request that the run-control logic acts on.

The unit applies the micro-operations in a fixed order. It first evaluates the selected condition tests against the incoming accumulator and link. Then it may clear the accumulator. Then it may OR the switch word into the result. The halt request comes last and touches no data. A sense bit in the instruction chooses between two ways of combining the tests. In one, any selected true condition causes a skip. In the other, every selected inverted condition must hold. Words that do not belong to this class produce no skip and no halt, and they pass the accumulator through unchanged.

Bit positions below use the usual vector indexing, with bit 11 as the most significant bit. Values are written in octal.

Top module: `g2op_unit`

## Requirements
- R1: The unit acts only when instr[11:8] are all ones and instr[0] is 0. The result flag `hit` is 1 exactly for such words. Any other word gives skip 0, halt 0 and ac_out equal to ac_in.
- R2: With the sense bit instr[3] at 0, the unit skips if any selected test is true. The tests are: instr[6] selects accumulator sign bit (ac_in[11]) set, instr[5] selects accumulator equal to zero, and instr[4] selects link equal to 1. Examples are 7500, 7440, 7420 and their combinations.
- R3: With instr[3] at 1, the unit skips only if every selected inverted test holds. The inverted tests are: sign bit clear (7510), accumulator nonzero (7450) and link clear (7430).
- R4: Word 7410, with the sense bit set and no test selected, always skips. Word 7400 never skips.
- R5: The skip tests use the accumulator value from before any clear. For example, 7640 with AC=0000 skips and returns 0000.
- R6: instr[7] clears the accumulator. When combined with instr[2], the switch word is ORed in after the clear, so 7604 returns exactly the switch word.
- R7: instr[2] without a clear returns ac_in OR switches.
- R8: instr[1] raises halt. A pure halt word (7402) returns the accumulator unchanged and does not skip.
- R9: Results, `hit` and `res_valid` appear on the clock edge after the one that samples op_valid=1. After reset all outputs are 0.
- R10: An edge with op_valid=0 drives res_valid, hit, skip and halt to 0 and keeps ac_out at its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction strobe; inputs are sampled when high |
| instr | input | 12 | Instruction word |
| ac_in | input | AC_W | Accumulator before execution |
| link_in | input | 1 | Link bit |
| switches | input | AC_W | Switch register word |
| res_valid | output | 1 | Results below belong to the last strobed word |
| hit | output | 1 | The last strobed word belonged to this class |
| skip | output | 1 | Skip decision |
| halt | output | 1 | Halt request |
| ac_out | output | AC_W | New accumulator value |

## Verification
The properties assume that each input is stable at the clock edge where op_valid is sampled. They also assume that reset is held for at least one edge before the first strobe. The bench drives every input on the falling edge and reads every output on the following falling edge, so the values the properties look back to with $past are always the ones that were applied. Words outside the class, including words with only the least significant bit different, are mixed into the stimulus. This lets the properties on clearing, ORing and halting check that these effects stay confined to decoded words.

// File: rtl/g2op_pkg.sv
package g2op_pkg;

  localparam int INSTR_W = 12;

  // Field positions inside the instruction word (bit 11 = most significant)
  localparam int B_CLR   = 7;
  localparam int B_SIGN  = 6;
  localparam int B_ZERO  = 5;
  localparam int B_LINK  = 4;
  localparam int B_SENSE = 3;
  localparam int B_OR_SW = 2;
  localparam int B_STOP  = 1;
  localparam int B_XCLS  = 0;

  typedef struct packed {
    logic member;
    logic clr;
    logic t_sign;
    logic t_zero;
    logic t_link;
    logic sense_and;
    logic or_sw;
    logic stop;
  } g2_fields_t;

  function automatic logic is_member(input logic [INSTR_W-1:0] w);
    return (w[11:9] == 3'b111) && w[8] && !w[B_XCLS];
  endfunction

  function automatic g2_fields_t split_fields(input logic [INSTR_W-1:0] w);
    g2_fields_t f;
    f.member    = is_member(w);
    f.clr       = w[B_CLR];
    f.t_sign    = w[B_SIGN];
    f.t_zero    = w[B_ZERO];
    f.t_link    = w[B_LINK];
    f.sense_and = w[B_SENSE];
    f.or_sw     = w[B_OR_SW];
    f.stop      = w[B_STOP];
    return f;
  endfunction

  // AND of inverted tests equals NOT of OR of plain tests
  function automatic logic skip_combine(input logic any_true, input logic sense_and);
    return any_true ^ sense_and;
  endfunction

endpackage

// File: rtl/g2op_decode.sv
module g2op_decode
  import g2op_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output g2_fields_t         fields
);

  always_comb begin
    fields = split_fields(instr);
  end

endmodule

// File: rtl/g2op_skip.sv
module g2op_skip
  import g2op_pkg::*;
#(
  parameter int AC_W = 12
) (
  input  g2_fields_t        fields,
  input  logic [AC_W-1:0]   ac,
  input  logic              link,
  output logic              any_true,
  output logic              skip
);

  localparam int SIGN_BIT = AC_W - 1;

  logic ac_is_zero;
  logic ac_neg;
  logic [2:0] sel;
  logic [2:0] cond;

  always_comb begin
    ac_is_zero = (ac == '0);
    ac_neg     = ac[SIGN_BIT];
    sel        = {fields.t_sign, fields.t_zero, fields.t_link};
    cond       = {ac_neg, ac_is_zero, link};
    any_true   = |(sel & cond);
    skip       = fields.member & skip_combine(any_true, fields.sense_and);
  end

endmodule

// File: rtl/g2op_acpath.sv
module g2op_acpath
  import g2op_pkg::*;
#(
  parameter int AC_W = 12
) (
  input  g2_fields_t        fields,
  input  logic [AC_W-1:0]   ac,
  input  logic [AC_W-1:0]   sw,
  output logic [AC_W-1:0]   ac_cleared,
  output logic [AC_W-1:0]   ac_next
);

  function automatic logic [AC_W-1:0] stage_clear(input logic [AC_W-1:0] v, input logic en);
    return en ? '0 : v;
  endfunction

  function automatic logic [AC_W-1:0] stage_or(input logic [AC_W-1:0] v,
                                               input logic [AC_W-1:0] s,
                                               input logic en);
    return en ? (v | s) : v;
  endfunction

  always_comb begin
    ac_cleared = stage_clear(ac, fields.member & fields.clr);
    ac_next    = stage_or(ac_cleared, sw, fields.member & fields.or_sw);
  end

endmodule

// File: rtl/g2op_unit.sv
module g2op_unit
  import g2op_pkg::*;
#(
  parameter int AC_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [AC_W-1:0]     ac_in,
  input  logic                link_in,
  input  logic [AC_W-1:0]     switches,
  output logic                res_valid,
  output logic                hit,
  output logic                skip,
  output logic                halt,
  output logic [AC_W-1:0]     ac_out
);

  g2_fields_t      fields;
  logic            any_true;
  logic            skip_now;
  logic [AC_W-1:0] ac_cleared;
  logic [AC_W-1:0] ac_now;
  logic            halt_now;

  g2op_decode u_decode (
    .instr  (instr),
    .fields (fields)
  );

  g2op_skip #(.AC_W(AC_W)) u_skip (
    .fields   (fields),
    .ac       (ac_in),
    .link     (link_in),
    .any_true (any_true),
    .skip     (skip_now)
  );

  g2op_acpath #(.AC_W(AC_W)) u_acpath (
    .fields     (fields),
    .ac         (ac_in),
    .sw         (switches),
    .ac_cleared (ac_cleared),
    .ac_next    (ac_now)
  );

  assign halt_now = fields.member & fields.stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      skip      <= 1'b0;
      halt      <= 1'b0;
      ac_out    <= '0;
    end else if (op_valid) begin
      res_valid <= 1'b1;
      hit       <= fields.member;
      skip      <= skip_now;
      halt      <= halt_now;
      ac_out    <= ac_now;
    end else begin
      res_valid <= 1'b0;
      hit       <= 1'b0;
      skip      <= 1'b0;
      halt      <= 1'b0;
    end
  end

endmodule

// File: rtl/g2op_unit_chk.sv
module g2op_unit_chk #(
  parameter int AC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [11:0]     instr,
  input logic [AC_W-1:0] ac_in,
  input logic            link_in,
  input logic [AC_W-1:0] switches,
  input logic            res_valid,
  input logic            hit,
  input logic            skip,
  input logic            halt,
  input logic [AC_W-1:0] ac_out
);

  logic in_class;
  assign in_class = (instr[11:8] == 4'hF) && (instr[0] == 1'b0);

  p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !in_class) |=> (!hit && !skip && !halt && ac_out == $past(ac_in)));

  p_inside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_class) |=> hit);

  p_or_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_class && !instr[3] && instr[6] && ac_in[AC_W-1]) |=> skip);

  p_and_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_class && instr[3] && instr[6] && ac_in[AC_W-1]) |=> !skip);

  p_uncond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && instr == 12'o7410) |=> skip);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_class && instr[7] && !instr[2]) |=> (ac_out == '0));

  p_or_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_class && instr[2]) |=> ((ac_out & $past(switches)) == $past(switches)));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_class && instr[1]) |=> halt);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && !hit && !skip && !halt && $stable(ac_out)));

  p_flags_need_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!skip && !halt && !hit));

  p_link_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && in_class && instr[5:3] == 3'b010 && !instr[6] && link_in) |=> skip);

endmodule

bind g2op_unit g2op_unit_chk #(.AC_W(AC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .instr     (instr),
  .ac_in     (ac_in),
  .link_in   (link_in),
  .switches  (switches),
  .res_valid (res_valid),
  .hit       (hit),
  .skip      (skip),
  .halt      (halt),
  .ac_out    (ac_out)
);

// File: tb/g2op_unit_tb.sv
module g2op_unit_tb;

  localparam int AC_W = 12;
  localparam int NV   = 34;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic [11:0]     instr = '0;
  logic [AC_W-1:0] ac_in = '0;
  logic            link_in = 1'b0;
  logic [AC_W-1:0] switches = '0;
  logic            res_valid, hit, skip, halt;
  logic [AC_W-1:0] ac_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  g2op_unit #(.AC_W(AC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
    .ac_in(ac_in), .link_in(link_in), .switches(switches),
    .res_valid(res_valid), .hit(hit), .skip(skip), .halt(halt), .ac_out(ac_out)
  );

  // Vector: req(4) instr(12) ac(12) link(1) sw(12) exp_hit(1) exp_skip(1) exp_ac(12) exp_halt(1)
  localparam logic [55:0] VEC [NV] = '{
    {4'd2, 12'o7500, 12'o4000, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o4000, 1'b0},
    {4'd2, 12'o7500, 12'o3777, 1'b0, 12'o0000, 1'b1, 1'b0, 12'o3777, 1'b0},
    {4'd2, 12'o7440, 12'o0000, 1'b1, 12'o0000, 1'b1, 1'b1, 12'o0000, 1'b0},
    {4'd2, 12'o7440, 12'o0100, 1'b1, 12'o0000, 1'b1, 1'b0, 12'o0100, 1'b0},
    {4'd2, 12'o7420, 12'o0123, 1'b1, 12'o0000, 1'b1, 1'b1, 12'o0123, 1'b0},
    {4'd2, 12'o7420, 12'o0123, 1'b0, 12'o0000, 1'b1, 1'b0, 12'o0123, 1'b0},
    {4'd2, 12'o7560, 12'o0001, 1'b0, 12'o0000, 1'b1, 1'b0, 12'o0001, 1'b0},
    {4'd2, 12'o7560, 12'o0001, 1'b1, 12'o0000, 1'b1, 1'b1, 12'o0001, 1'b0},
    {4'd3, 12'o7510, 12'o3777, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o3777, 1'b0},
    {4'd3, 12'o7510, 12'o4000, 1'b0, 12'o0000, 1'b1, 1'b0, 12'o4000, 1'b0},
    {4'd3, 12'o7450, 12'o0000, 1'b0, 12'o0000, 1'b1, 1'b0, 12'o0000, 1'b0},
    {4'd3, 12'o7450, 12'o0005, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o0005, 1'b0},
    {4'd3, 12'o7430, 12'o0070, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o0070, 1'b0},
    {4'd3, 12'o7430, 12'o0070, 1'b1, 12'o0000, 1'b1, 1'b0, 12'o0070, 1'b0},
    {4'd3, 12'o7570, 12'o0005, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o0005, 1'b0},
    {4'd3, 12'o7570, 12'o4005, 1'b0, 12'o0000, 1'b1, 1'b0, 12'o4005, 1'b0},
    {4'd3, 12'o7570, 12'o0005, 1'b1, 12'o0000, 1'b1, 1'b0, 12'o0005, 1'b0},
    {4'd4, 12'o7410, 12'o1234, 1'b1, 12'o0000, 1'b1, 1'b1, 12'o1234, 1'b0},
    {4'd4, 12'o7400, 12'o0000, 1'b1, 12'o0000, 1'b1, 1'b0, 12'o0000, 1'b0},
    {4'd5, 12'o7640, 12'o0000, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o0000, 1'b0},
    {4'd5, 12'o7650, 12'o0017, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o0000, 1'b0},
    {4'd5, 12'o7700, 12'o4001, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o0000, 1'b0},
    {4'd6, 12'o7600, 12'o5555, 1'b0, 12'o7070, 1'b1, 1'b0, 12'o0000, 1'b0},
    {4'd6, 12'o7604, 12'o5555, 1'b0, 12'o1212, 1'b1, 1'b0, 12'o1212, 1'b0},
    {4'd7, 12'o7404, 12'o0707, 1'b0, 12'o1010, 1'b1, 1'b0, 12'o1717, 1'b0},
    {4'd7, 12'o7404, 12'o0000, 1'b0, 12'o0000, 1'b1, 1'b0, 12'o0000, 1'b0},
    {4'd8, 12'o7402, 12'o2222, 1'b1, 12'o7777, 1'b1, 1'b0, 12'o2222, 1'b1},
    {4'd8, 12'o7606, 12'o3333, 1'b0, 12'o0044, 1'b1, 1'b0, 12'o0044, 1'b1},
    {4'd8, 12'o7412, 12'o0001, 1'b0, 12'o0000, 1'b1, 1'b1, 12'o0001, 1'b1},
    {4'd1, 12'o7401, 12'o1111, 1'b1, 12'o7777, 1'b0, 1'b0, 12'o1111, 1'b0},
    {4'd1, 12'o7200, 12'o1111, 1'b1, 12'o7777, 1'b0, 1'b0, 12'o1111, 1'b0},
    {4'd1, 12'o6402, 12'o1111, 1'b1, 12'o7777, 1'b0, 1'b0, 12'o1111, 1'b0},
    {4'd1, 12'o3410, 12'o1111, 1'b1, 12'o7777, 1'b0, 1'b0, 12'o1111, 1'b0},
    {4'd1, 12'o7607, 12'o1111, 1'b1, 12'o7777, 1'b0, 1'b0, 12'o1111, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AC_W-1:0] act, input logic [AC_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%o expected=%o", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0 && hit == 1'b0, "R9", "reset valid/hit", {10'd0, res_valid, hit}, '0);
    check(skip == 1'b0 && halt == 1'b0, "R9", "reset skip/halt", {10'd0, skip, halt}, '0);
    check(ac_out == '0, "R9", "reset ac_out", ac_out, '0);
    rst_n = 1'b1;

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[55:52]);
      @(negedge clk);
      op_valid = 1'b1;
      instr    = v[51:40];
      ac_in    = v[39:28];
      link_in  = v[27];
      switches = v[26:15];
      @(negedge clk);
      op_valid = 1'b0;
      check(res_valid == 1'b1, "R9", "res_valid", {11'd0, res_valid}, 12'd1);
      check(hit == v[14], rq, "hit", {11'd0, hit}, {11'd0, v[14]});
      check(skip == v[13], rq, "skip", {11'd0, skip}, {11'd0, v[13]});
      check(ac_out == v[12:1], rq, "ac_out", ac_out, v[12:1]);
      check(halt == v[0], rq, "halt", {11'd0, halt}, {11'd0, v[0]});
    end

    // R10: an idle edge drops flags and holds the accumulator
    @(negedge clk);
    op_valid = 1'b1; instr = 12'o7412; ac_in = 12'o4321; link_in = 1'b0; switches = '0;
    @(negedge clk);
    op_valid = 1'b0; instr = 12'o7606; ac_in = 12'o0000; switches = 12'o7777;
    check(skip && halt && ac_out == 12'o4321, "R8", "skip+halt word", ac_out, 12'o4321);
    @(negedge clk);
    check(!res_valid && !hit && !skip && !halt, "R10", "idle flags",
          {8'd0, res_valid, hit, skip, halt}, '0);
    check(ac_out == 12'o4321, "R10", "idle ac hold", ac_out, 12'o4321);

    // R9: back-to-back strobes, each result one edge after its strobe
    op_valid = 1'b1; instr = 12'o7604; ac_in = 12'o0000; switches = 12'o0550;
    @(negedge clk);
    check(ac_out == 12'o0550, "R9", "back-to-back first", ac_out, 12'o0550);
    instr = 12'o7404; ac_in = 12'o1001; switches = 12'o0010;
    @(negedge clk);
    op_valid = 1'b0;
    check(ac_out == 12'o1011 && res_valid, "R9", "back-to-back second", ac_out, 12'o1011);

    // R5: clear combined with a sign test uses the uncleared value
    @(negedge clk);
    op_valid = 1'b1; instr = 12'o7710; ac_in = 12'o4000; link_in = 1'b0;
    @(negedge clk);
    op_valid = 1'b0;
    check(!skip && ac_out == '0, "R5", "7710 pre-clear sign", {11'd0, skip}, '0);

    // R9: reset in the middle clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(!res_valid && ac_out == '0, "R9", "mid reset", ac_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule